// File: doc/BRIEF.md
# Permuted Program-Bank Mapper

This block sits on the cartridge side of an 8-bit CPU bus. It maps CPU read addresses from $6000 to $FFFF onto 8 KiB banks of a program ROM. The range is split into five 8 KiB windows. Four windows are tied to constant banks. The window at $C000 takes its bank from a 4-bit register. That register is not used as the bank number directly: its bits are reordered first.

The CPU loads the register by writing in the expansion area below $6000. The decode checks only a few address bits, so the register appears at many addresses in that area. The translation side is purely combinational. From `cpu_addr` it produces:

- a ROM-select flag,
- a physical bank index, reduced modulo the number of banks actually fitted,
- the 13-bit offset inside that bank.

A downstream ROM array uses these three outputs directly.

Top module: `prg_scramble_mapper`

## Requirements
- R1: A write strobe whose address is above $5FFF leaves the bank register unchanged.
- R2: On a rising clock edge where `cpu_wr` is high, `cpu_addr` is at most $5FFF, and (`cpu_addr` AND $4120) equals $4020, the register loads `cpu_wdata[3:0]`. Bits [7:4] of the data are discarded.
- R3: A write at or below $5FFF that does not satisfy the mask condition of R2 leaves the register unchanged.
- R4: For addresses $C000–$DFFF, the un-reduced bank is built from register bits in this order, from bit 3 down to bit 0: {reg[3], reg[0], reg[2], reg[1]}.
- R5: For addresses $6000–$7FFF, the un-reduced bank is $0F.
- R6: For $8000–$9FFF the un-reduced bank is $08. For $A000–$BFFF it is $09. For $E000–$FFFF it is $0B.
- R7: While reset is asserted, and after it is released, the register holds 0, so the $C000 window selects bank 0.
- R8: While `rom_sel` is high, `rom_offset` equals `cpu_addr[12:0]`.
- R9: For addresses below $6000, `rom_sel` is low and both `rom_bank` and `rom_offset` are 0.
- R10: `rom_bank` is the un-reduced bank modulo `ROM_BANKS`. With the default of 12 banks, bank $0F becomes 3 and bank 14 becomes 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address, used for both reads and writes |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| rom_sel | output | 1 | High when `cpu_addr` falls in a ROM window |
| rom_bank | output | BANK_W ($clog2(ROM_BANKS), 4 by default) | Physical ROM bank index |
| rom_offset | output | 13 | Byte offset inside the 8 KiB bank |

## Verification
The hardest case to reach from the ports is a register write through a mirror address of the sparse decode. A closely related case is an address that differs from a mirror only in bit 8 or bit 14, which must be rejected.

The vector table writes through several mirrors: $5020, $40A0 and $4E3F. It also writes through near misses: $4120, $5FE0, $0020, and addresses above the write limit. After each write the bench reads the $C000 window. The permutation and the modulo-12 wrap together expose any stray update, because every write in the table changes the bank that would be produced.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int REG_W  = 4;
  localparam int OFS_W  = 13;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_LOW  = 3'd1,
    WIN_B8   = 3'd2,
    WIN_BA   = 3'd3,
    WIN_BC   = 3'd4,
    WIN_BE   = 3'd5
  } win_e;

  // Reorder register bits into the switchable bank number.
  function automatic logic [REG_W-1:0] permute_bank(input logic [REG_W-1:0] r);
    return {r[3], r[0], r[2], r[1]};
  endfunction

  // Classify an address by its top three bits into a ROM window.
  function automatic win_e classify(input logic [ADDR_W-1:0] a);
    win_e w;
    case (a[ADDR_W-1:OFS_W])
      3'b011:  w = WIN_LOW;
      3'b100:  w = WIN_B8;
      3'b101:  w = WIN_BA;
      3'b110:  w = WIN_BC;
      3'b111:  w = WIN_BE;
      default: w = WIN_NONE;
    endcase
    return w;
  endfunction

  // Sparse write decode match.
  function automatic logic decode_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] mask,
                                      input logic [ADDR_W-1:0] match);
    return (a & mask) == match;
  endfunction

endpackage

// File: rtl/mapper_wr_decode.sv
module mapper_wr_decode
  import mapper_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WR_LIMIT = 16'h5FFF,
  parameter logic [ADDR_W-1:0] WR_MASK  = 16'h4120,
  parameter logic [ADDR_W-1:0] WR_MATCH = 16'h4020
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  output logic              wr_blocked,
  output logic              wr_hit
);

  logic in_range;
  logic mask_ok;

  always_comb begin
    in_range   = cpu_addr <= WR_LIMIT;
    mask_ok    = decode_hit(cpu_addr, WR_MASK, WR_MATCH);
    wr_blocked = cpu_wr && !in_range;
    wr_hit     = cpu_wr && in_range && mask_ok;
  end

endmodule

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg
  import mapper_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_VAL;
    else if (load) q <= din;
  end

endmodule

// File: rtl/mapper_window_xlate.sv
module mapper_window_xlate
  import mapper_pkg::*;
#(
  parameter int               ROM_BANKS = 12,
  parameter logic [REG_W-1:0] BANK_LOW  = 4'hF,
  parameter logic [REG_W-1:0] BANK_B8   = 4'h8,
  parameter logic [REG_W-1:0] BANK_BA   = 4'h9,
  parameter logic [REG_W-1:0] BANK_BE   = 4'hB,
  localparam int              BANK_W    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  bank_reg,
  output logic              sel,
  output logic [REG_W-1:0]  raw_bank,
  output logic [BANK_W-1:0] bank,
  output logic [OFS_W-1:0]  offset
);

  win_e win;

  always_comb begin
    win = classify(cpu_addr);
    sel = (win != WIN_NONE);
    case (win)
      WIN_LOW: raw_bank = BANK_LOW;
      WIN_B8:  raw_bank = BANK_B8;
      WIN_BA:  raw_bank = BANK_BA;
      WIN_BC:  raw_bank = permute_bank(bank_reg);
      WIN_BE:  raw_bank = BANK_BE;
      default: raw_bank = '0;
    endcase
    offset = sel ? cpu_addr[OFS_W-1:0] : '0;
  end

  generate
    if (ROM_BANKS >= (1 << REG_W)) begin : g_no_wrap
      always_comb bank = BANK_W'(raw_bank);
    end else begin : g_wrap
      always_comb bank = BANK_W'(int'(raw_bank) % ROM_BANKS);
    end
  endgenerate

endmodule

// File: rtl/prg_scramble_mapper.sv
module prg_scramble_mapper
  import mapper_pkg::*;
#(
  parameter int  ROM_BANKS = 12,
  localparam int BANK_W    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  output logic              rom_sel,
  output logic [BANK_W-1:0] rom_bank,
  output logic [12:0]       rom_offset
);

  // Named internal events, observed by the bound checker.
  logic             wr_hit;
  logic             wr_blocked;
  logic [REG_W-1:0] bank_q;
  logic [REG_W-1:0] raw_bank;
  logic             unused_hi;

  assign unused_hi = ^cpu_wdata[DATA_W-1:REG_W];

  mapper_wr_decode u_dec (
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .wr_blocked (wr_blocked),
    .wr_hit     (wr_hit)
  );

  mapper_bank_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_hit),
    .din   (cpu_wdata[REG_W-1:0]),
    .q     (bank_q)
  );

  mapper_window_xlate #(.ROM_BANKS(ROM_BANKS)) u_xl (
    .cpu_addr (cpu_addr),
    .bank_reg (bank_q),
    .sel      (rom_sel),
    .raw_bank (raw_bank),
    .bank     (rom_bank),
    .offset   (rom_offset)
  );

endmodule

// File: rtl/mapper_chk.sv
module mapper_chk #(
  parameter int ROM_BANKS = 12,
  parameter int BANK_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_wr,
  input logic              wr_hit,
  input logic              wr_blocked,
  input logic [3:0]        bank_q,
  input logic [3:0]        raw_bank,
  input logic              rom_sel,
  input logic [BANK_W-1:0] rom_bank,
  input logic [12:0]       rom_offset
);

  // Bit-by-bit restatement of the bank-bit reordering, written as masks and shifts.
  logic [3:0] perm_exp;
  assign perm_exp = (bank_q & 4'h8) | ((bank_q & 4'h1) << 2) | ((bank_q >> 1) & 4'h3);

  assert_wr_ignored_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr > 16'h5FFF) |=> $stable(bank_q));

  assert_wr_blocked_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> !wr_hit);

  assert_wr_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> bank_q == $past(cpu_wdata[3:0]));

  assert_no_hit_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bank_q));

  assert_c000_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'hC000 && cpu_addr < 16'hE000) |-> raw_bank == perm_exp);

  assert_6000_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'h6000 && cpu_addr < 16'h8000) |-> raw_bank == 4'hF);

  assert_e000_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'hE000) |-> raw_bank == 4'hB);

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> bank_q == 4'h0);

  assert_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> rom_offset == cpu_addr[12:0]);

  assert_low_unselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> (!rom_sel && rom_bank == '0 && rom_offset == '0));

  assert_modulo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (int'(rom_bank) < ROM_BANKS &&
                 int'(rom_bank) == int'(raw_bank) % ROM_BANKS));

endmodule

bind prg_scramble_mapper mapper_chk #(.ROM_BANKS(ROM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_wr     (cpu_wr),
  .wr_hit     (wr_hit),
  .wr_blocked (wr_blocked),
  .bank_q     (bank_q),
  .raw_bank   (raw_bank),
  .rom_sel    (rom_sel),
  .rom_bank   (rom_bank),
  .rom_offset (rom_offset)
);

// File: tb/test_prg_scramble_mapper.sv
module test_prg_scramble_mapper;

  localparam int ROM_BANKS = 12;
  localparam int BANK_W    = 4;
  localparam int NVEC      = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       cpu_addr = 16'h0000;
  logic [7:0]        cpu_wdata = 8'h00;
  logic              cpu_wr = 1'b0;
  logic              rom_sel;
  logic [BANK_W-1:0] rom_bank;
  logic [12:0]       rom_offset;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  prg_scramble_mapper #(.ROM_BANKS(ROM_BANKS)) i_prg_scramble_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_wr     (cpu_wr),
    .rom_sel    (rom_sel),
    .rom_bank   (rom_bank),
    .rom_offset (rom_offset)
  );

  // Each entry is {write address, write data, expected $C000 bank after the write}, modulo 12.
  localparam logic [27:0] VEC [NVEC] = '{
    {16'h4020, 8'h02, 4'd1},
    {16'h5020, 8'h01, 4'd4},
    {16'h40A0, 8'h08, 4'd8},
    {16'h4E3F, 8'hF2, 4'd1},
    {16'h4020, 8'h04, 4'd2},
    {16'h4120, 8'h0F, 4'd2},
    {16'h6020, 8'h0F, 4'd2},
    {16'h4020, 8'h0F, 4'd3},
    {16'h0020, 8'h01, 4'd3},
    {16'h4020, 8'h0D, 4'd2},
    {16'h8020, 8'h08, 4'd2},
    {16'h5FE0, 8'h06, 4'd2},
    {16'h4020, 8'h06, 4'd3},
    {16'h4020, 8'h09, 4'd0},
    {16'h4020, 8'h0B, 4'd1},
    {16'hFFFF, 8'h00, 4'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr    = 1'b0;
  endtask

  task automatic read_at(input logic [15:0] a);
    cpu_addr = a;
    #1;
  endtask

  function automatic string vec_req(input logic [15:0] a);
    if (a > 16'h5FFF) return "R1";
    else if ((a & 16'h4120) == 16'h4020) return "R2";
    else return "R3";
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    read_at(16'hC000);
    check("R7 reset C000 bank", 32'(rom_bank), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_at(16'hC000);
    check("R7 after release", 32'(rom_bank), 32'd0);
    check("R8 sel at C000", 32'(rom_sel), 32'd1);

    // Fixed windows, offsets and modulo wrap.
    read_at(16'h6000); check("R5 6000 bank (R10 wrap)", 32'(rom_bank), 32'd3);
    read_at(16'h7FFF); check("R8 7FFF offset", 32'(rom_offset), 32'h1FFF);
    check("R5 7FFF bank", 32'(rom_bank), 32'd3);
    read_at(16'h8000); check("R6 8000 bank", 32'(rom_bank), 32'd8);
    read_at(16'hA123); check("R6 A000 bank", 32'(rom_bank), 32'd9);
    check("R8 A123 offset", 32'(rom_offset), 32'h0123);
    read_at(16'hE000); check("R6 E000 bank", 32'(rom_bank), 32'd11);
    read_at(16'hD234); check("R8 D234 offset", 32'(rom_offset), 32'h1234);
    read_at(16'h5FFF);
    check("R9 5FFF sel", 32'(rom_sel), 32'd0);
    check("R9 5FFF bank", 32'(rom_bank), 32'd0);
    check("R9 5FFF offset", 32'(rom_offset), 32'd0);

    // Walk of the write vectors: every write is followed by a read of the $C000 window.
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][27:12], VEC[i][11:4]);
      read_at(16'hC000);
      check({vec_req(VEC[i][27:12]), " R4 R10 vec"}, 32'(rom_bank), 32'(VEC[i][3:0]));
    end

    // A write strobe with an address below $6000 must not select ROM.
    @(negedge clk);
    cpu_addr = 16'h4020; cpu_wdata = 8'h01; cpu_wr = 1'b1; #1;
    check("R9 sel during write", 32'(rom_sel), 32'd0);
    @(negedge clk);
    cpu_wr = 1'b0;
    read_at(16'hC000);
    check("R2 write with sel check", 32'(rom_bank), 32'd4);

    // A reset in mid-run clears the register.
    @(negedge clk);
    rst_n = 1'b0; #1;
    read_at(16'hC000);
    check("R7 mid-run reset", 32'(rom_bank), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_at(16'hC000);
    check("R7 post mid-run reset", 32'(rom_bank), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule